// File: doc/BRIEF.md
# Special-Order and Program-Level Unit

This unit carries out the special group of orders of an 18-bit processor. In that group a 13-bit field picks the operation instead of naming a memory word. The group holds register moves between the accumulator A, the extension register Q and the modifier register B. It also holds a conditional skip test on A, a step-and-test on B, a character-input shift, and the selection of the addressing mode. Two ranges of field values pass a word to or from a numbered peripheral channel. Field values that no rule names do nothing.

The order results are combinational. In the cycle that an order is presented, the unit drives write enables and new values toward the A, Q and B registers, and drives a skip request toward the sequencer. The sequencer latches them at the next clock edge.

The unit also keeps track of the program level. There are two levels: a high level and a low level. Reset leaves the machine on the high level, so interrupts stay masked until software leaves that level.

- **Entering the high level.** A request arriving on the low level starts a four-access memory sequence:
  - the running SCR and B are stored into two save words;
  - fresh SCR and B values are fetched from two vector words.
- **Leaving the high level.** The level-exit order fetches SCR and B back from the save words.

While a sequence runs, the unit reports busy and accepts no orders.

Top module: `sox_unit`

## Requirements
- R1: After reset the unit is on the high level (`level_top`=1), relative mode is off (`rel_mode`=0), `busy` is 0, and no write enable, skip or memory request is active.
- R2: Field 7169 raises `skip` when A is zero or when A bit 17 differs from A bit 16, and otherwise leaves `skip` low. It writes no register.
- R3: Field 7170 writes B+1 (modulo 2^18) to B. It raises `skip` when bits 12..0 of that new value are all zero.
- R4: Field 7172 writes {A[16:0],0} to Q. Field 7173 writes {0,Q[17:1]} to A, so A bit 17 is cleared.
- R5: Field 7174 writes A to B and 7175 writes B to A. Field 7176 sets `rel_mode` to 1 at the next edge, 7177 clears it, and no other input changes it.
- R6: Field 2048 writes to A the value (A shifted left by 7, truncated to 18 bits) ORed with the 7-bit `char_in`.
- R7: Fields 0..2047 (bits 12..11 = 00) raise `io_rd` and write `io_rdata` to A. Fields 4096..6143 (bits 12..11 = 10) raise `io_wr` with `io_wdata`=A. In both cases `io_chan` = field bits 10..0.
- R8: Any other field value (for example 3000, 7171, 8191) asserts no write enable, skip, I/O strobe or memory request.
- R9: When `irq` is high on the low level, with the unit idle and no order offered, the next cycles run four memory accesses. In order they are: write SCR to word 2, write B to word 3, read word 0, read word 1. The read data is written to SCR one cycle after the read of word 0 is issued and to B one cycle after the read of word 1 is issued. The unit is then idle on the high level.
- R10: `irq` has no effect while the unit is on the high level.
- R11: Field 7168 on the high level reads word 2 and then word 3. The read data is written to SCR and then to B in the same one-cycle-late way as entry. The unit is then idle on the low level. On the low level, 7168 has no effect.
- R12: While `busy` is 1, an offered order has no effect on A, Q, B, skip or I/O.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | A special order is offered this cycle |
| op_field | input | 13 | Order field selecting the operation |
| a_in | input | 18 | Current A |
| q_in | input | 18 | Current Q |
| b_in | input | 18 | Current B |
| scr_in | input | 18 | Current sequence control register |
| char_in | input | 7 | Input character for field 2048 |
| io_rdata | input | 18 | Word returned by the addressed channel |
| irq | input | 1 | High-level interrupt request |
| mem_rdata | input | 18 | Read data, valid the cycle after a read request |
| a_we | output | 1 | Write enable for A |
| a_wd | output | 18 | New A |
| q_we | output | 1 | Write enable for Q |
| q_wd | output | 18 | New Q |
| b_we | output | 1 | Write enable for B |
| b_wd | output | 18 | New B |
| scr_we | output | 1 | Write enable for SCR |
| scr_wd | output | 18 | New SCR |
| skip | output | 1 | Skip the next instruction |
| rel_mode | output | 1 | Relative addressing mode selected |
| level_top | output | 1 | 1 = high level, 0 = low level |
| busy | output | 1 | Level entry or exit in progress |
| io_rd | output | 1 | Input strobe |
| io_wr | output | 1 | Output strobe |
| io_chan | output | 11 | Channel number |
| io_wdata | output | 18 | Output word |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 15 | Memory word address |
| mem_wdata | output | 18 | Memory write data |

## Verification
Some properties are checked on every cycle:
- memory writes only ever target the two save words;
- the level flag moves only at the last step of an entry or exit, and in the correct direction;
- `rel_mode` changes only after a mode order;
- skip is raised only by the two test orders;
- at most one register destination is written per order;
- no order result leaks out while busy.

Only the bench scenarios can show:
- the arithmetic results of each order;
- the exact ordering and one-cycle read latency of the save and load accesses;
- that interrupts are masked on the high level after reset.

// File: rtl/sox_pkg.sv
package sox_pkg;
  localparam int WORD = 18;
  localparam int FLD  = 13;
  localparam int CHW  = 7;
  localparam int CHAN = 11;

  typedef logic [WORD-1:0] word_t;

  localparam logic [FLD-1:0] OP_EXIT = 13'd7168;
  localparam logic [FLD-1:0] OP_TSTD = 13'd7169;
  localparam logic [FLD-1:0] OP_BINC = 13'd7170;
  localparam logic [FLD-1:0] OP_A2Q  = 13'd7172;
  localparam logic [FLD-1:0] OP_Q2A  = 13'd7173;
  localparam logic [FLD-1:0] OP_A2B  = 13'd7174;
  localparam logic [FLD-1:0] OP_B2A  = 13'd7175;
  localparam logic [FLD-1:0] OP_REL  = 13'd7176;
  localparam logic [FLD-1:0] OP_ABS  = 13'd7177;
  localparam logic [FLD-1:0] OP_CHIN = 13'd2048;

  typedef enum logic [3:0] {
    S_IDLE, S_ESCR, S_EB, S_ER0, S_ER1, S_EFIN, S_XR2, S_XR3, S_XFIN
  } lvl_state_t;

  // zero, or the two top bits disagree
  function automatic logic f_standard(word_t a);
    return (a == '0) || (a[WORD-1] != a[WORD-2]);
  endfunction

  function automatic word_t f_step_b(word_t b);
    return b + word_t'(1);
  endfunction

  function automatic logic f_b_wraps(word_t nb);
    return nb[12:0] == 13'd0;
  endfunction

  function automatic word_t f_char_shift(word_t a, logic [CHW-1:0] ch);
    return (a << CHW) | word_t'(ch);
  endfunction

  function automatic word_t f_a_to_q(word_t a);
    return {a[WORD-2:0], 1'b0};
  endfunction

  function automatic word_t f_q_to_a(word_t q);
    return {1'b0, q[WORD-1:1]};
  endfunction
endpackage

// File: rtl/sox_order_dec.sv
module sox_order_dec
  import sox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [FLD-1:0]    field,
  input  word_t             a_in,
  input  word_t             q_in,
  input  word_t             b_in,
  input  logic [CHW-1:0]    char_in,
  input  word_t             io_rdata,
  output logic              a_we,
  output word_t             a_wd,
  output logic              q_we,
  output word_t             q_wd,
  output logic              b_we,
  output word_t             b_wd,
  output logic              skip,
  output logic              io_rd,
  output logic              io_wr,
  output logic              mode_set,
  output logic              mode_rel,
  output logic              exit_req
);
  always_comb begin
    a_we = 1'b0; a_wd = a_in;
    q_we = 1'b0; q_wd = q_in;
    b_we = 1'b0; b_wd = b_in;
    skip = 1'b0; io_rd = 1'b0; io_wr = 1'b0;
    mode_set = 1'b0; mode_rel = 1'b0; exit_req = 1'b0;
    if (en) begin
      if (field[FLD-1:FLD-2] == 2'b00) begin
        io_rd = 1'b1; a_we = 1'b1; a_wd = io_rdata;
      end else if (field[FLD-1:FLD-2] == 2'b10) begin
        io_wr = 1'b1;
      end else begin
        case (field)
          OP_CHIN: begin a_we = 1'b1; a_wd = f_char_shift(a_in, char_in); end
          OP_EXIT: exit_req = 1'b1;
          OP_TSTD: skip = f_standard(a_in);
          OP_BINC: begin
            b_we = 1'b1; b_wd = f_step_b(b_in); skip = f_b_wraps(f_step_b(b_in));
          end
          OP_A2Q:  begin q_we = 1'b1; q_wd = f_a_to_q(a_in); end
          OP_Q2A:  begin a_we = 1'b1; a_wd = f_q_to_a(q_in); end
          OP_A2B:  begin b_we = 1'b1; b_wd = a_in; end
          OP_B2A:  begin a_we = 1'b1; a_wd = b_in; end
          OP_REL:  begin mode_set = 1'b1; mode_rel = 1'b1; end
          OP_ABS:  mode_set = 1'b1;
          default: ;
        endcase
      end
    end
  end

  // R2 / R3: only the two test orders can request a skip
  p_skip_codes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> en && (field == OP_TSTD || field == OP_BINC));
  // R8: one destination register per order at most
  p_one_dest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({a_we, q_we, b_we}));
  // R7: a channel is never read and written in the same order
  p_io_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd && io_wr));
endmodule

// File: rtl/sox_level_seq.sv
module sox_level_seq
  import sox_pkg::*;
#(
  parameter int AW       = 15,
  parameter int LOAD_SCR = 0,
  parameter int LOAD_B   = 1,
  parameter int SAVE_SCR = 2,
  parameter int SAVE_B   = 3
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq,
  input  logic          op_valid,
  input  logic          exit_req,
  input  word_t         scr_in,
  input  word_t         b_in,
  input  word_t         mem_rdata,
  output logic          busy,
  output logic          level_top,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output word_t         mem_wdata,
  output logic          scr_we,
  output word_t         scr_wd,
  output logic          b_we,
  output word_t         b_wd
);
  localparam logic [AW-1:0] A_LSCR = AW'(LOAD_SCR);
  localparam logic [AW-1:0] A_LB   = AW'(LOAD_B);
  localparam logic [AW-1:0] A_SSCR = AW'(SAVE_SCR);
  localparam logic [AW-1:0] A_SB   = AW'(SAVE_B);

  lvl_state_t state, nstate;
  logic enter_go, leave_go;

  assign enter_go = (state == S_IDLE) && irq && !level_top && !op_valid;
  assign leave_go = (state == S_IDLE) && exit_req && level_top;
  assign busy     = (state != S_IDLE);

  always_comb begin
    nstate = state;
    case (state)
      S_IDLE:  nstate = enter_go ? S_ESCR : (leave_go ? S_XR2 : S_IDLE);
      S_ESCR:  nstate = S_EB;
      S_EB:    nstate = S_ER0;
      S_ER0:   nstate = S_ER1;
      S_ER1:   nstate = S_EFIN;
      S_XR2:   nstate = S_XR3;
      S_XR3:   nstate = S_XFIN;
      default: nstate = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      level_top <= 1'b1;
    end else begin
      state <= nstate;
      if (state == S_EFIN) level_top <= 1'b1;
      else if (state == S_XFIN) level_top <= 1'b0;
    end
  end

  always_comb begin
    mem_req = 1'b0; mem_we = 1'b0; mem_addr = '0; mem_wdata = scr_in;
    scr_we = 1'b0; scr_wd = mem_rdata; b_we = 1'b0; b_wd = mem_rdata;
    case (state)
      S_ESCR: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = A_SSCR; end
      S_EB:   begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = A_SB; mem_wdata = b_in; end
      S_ER0:  begin mem_req = 1'b1; mem_addr = A_LSCR; end
      S_ER1:  begin mem_req = 1'b1; mem_addr = A_LB; scr_we = 1'b1; end
      S_EFIN: b_we = 1'b1;
      S_XR2:  begin mem_req = 1'b1; mem_addr = A_SSCR; end
      S_XR3:  begin mem_req = 1'b1; mem_addr = A_SB; scr_we = 1'b1; end
      S_XFIN: b_we = 1'b1;
      default: ;
    endcase
  end

  // R9: memory writes land only on the save words
  p_save_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req && (mem_addr == A_SSCR || mem_addr == A_SB));
  // R9: entry finishes on the high level, idle
  p_entry_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EFIN) |=> level_top && !busy);
  // R11: exit finishes on the low level
  p_exit_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_XFIN) |=> !level_top);
  // R10: no entry sequence starts from the high level
  p_masked_top_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (level_top && state == S_IDLE) |=> state != S_ESCR);
  // R1: the level flag moves only at the end of a sequence
  p_level_move_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level_top) |-> $past(state == S_EFIN || state == S_XFIN));
endmodule

// File: rtl/sox_unit.sv
module sox_unit
  import sox_pkg::*;
#(
  parameter int AW = 15
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [12:0]       op_field,
  input  logic [17:0]       a_in,
  input  logic [17:0]       q_in,
  input  logic [17:0]       b_in,
  input  logic [17:0]       scr_in,
  input  logic [6:0]        char_in,
  input  logic [17:0]       io_rdata,
  input  logic              irq,
  input  logic [17:0]       mem_rdata,
  output logic              a_we,
  output logic [17:0]       a_wd,
  output logic              q_we,
  output logic [17:0]       q_wd,
  output logic              b_we,
  output logic [17:0]       b_wd,
  output logic              scr_we,
  output logic [17:0]       scr_wd,
  output logic              skip,
  output logic              rel_mode,
  output logic              level_top,
  output logic              busy,
  output logic              io_rd,
  output logic              io_wr,
  output logic [10:0]       io_chan,
  output logic [17:0]       io_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [17:0]       mem_wdata
);
  logic  dec_en, dec_b_we, seq_b_we, mode_set, mode_rel, exit_req;
  word_t dec_b_wd, seq_b_wd;

  assign dec_en   = op_valid && !busy;
  assign io_chan  = op_field[CHAN-1:0];
  assign io_wdata = a_in;

  sox_order_dec u_dec (
    .clk(clk), .rst_n(rst_n), .en(dec_en), .field(op_field),
    .a_in(a_in), .q_in(q_in), .b_in(b_in), .char_in(char_in), .io_rdata(io_rdata),
    .a_we(a_we), .a_wd(a_wd), .q_we(q_we), .q_wd(q_wd),
    .b_we(dec_b_we), .b_wd(dec_b_wd), .skip(skip), .io_rd(io_rd), .io_wr(io_wr),
    .mode_set(mode_set), .mode_rel(mode_rel), .exit_req(exit_req)
  );

  sox_level_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .irq(irq), .op_valid(op_valid), .exit_req(exit_req),
    .scr_in(scr_in), .b_in(b_in), .mem_rdata(mem_rdata),
    .busy(busy), .level_top(level_top), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .scr_we(scr_we), .scr_wd(scr_wd),
    .b_we(seq_b_we), .b_wd(seq_b_wd)
  );

  assign b_we = dec_b_we | seq_b_we;
  assign b_wd = seq_b_we ? seq_b_wd : dec_b_wd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rel_mode <= 1'b0;
    else if (mode_set) rel_mode <= mode_rel;
  end

  // R5: the mode flag changes only after a mode order
  p_mode_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rel_mode) |-> $past(mode_set));
  // R12: no order result leaks out during a level sequence
  p_quiet_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !a_we && !q_we && !skip && !io_rd && !io_wr);
endmodule

// File: tb/tb_sox_unit.sv
module tb_sox_unit;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        op_valid = 1'b0, irq = 1'b0;
  logic [12:0] op_field = '0;
  logic [17:0] a_in = '0, q_in = '0, b_in = '0, scr_in = '0;
  logic [6:0]  char_in = '0;
  logic [17:0] io_rdata = 18'h2A5A5;
  logic [17:0] mem_rdata;
  logic        a_we, q_we, b_we, scr_we, skip, rel_mode, level_top, busy;
  logic        io_rd, io_wr, mem_req, mem_we;
  logic [17:0] a_wd, q_wd, b_wd, scr_wd, io_wdata, mem_wdata;
  logic [10:0] io_chan;
  logic [14:0] mem_addr;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  sox_unit dut (.*);

  // bench-side memory: synchronous read, one-cycle latency; preload port
  logic [17:0] mem [0:7];
  logic        pre_we = 1'b0;
  logic [2:0]  pre_addr = '0;
  logic [17:0] pre_data = '0;
  always @(posedge clk) begin
    if (pre_we) mem[pre_addr] <= pre_data;
    else if (mem_req && mem_we) mem[mem_addr[2:0]] <= mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[2:0]];
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [2:0] ad, input logic [17:0] d);
    @(negedge clk); pre_we = 1'b1; pre_addr = ad; pre_data = d;
    @(negedge clk); pre_we = 1'b0;
  endtask

  // {field13, a18, q18, b18, ch7, exp: awe, awd, qwe, qwd, bwe, bwd, skip}
  localparam int NV = 18;
  localparam logic [131:0] VEC [0:NV-1] = '{
    // R2 standardisation test
    {13'd7169, 18'h00000, 18'h0, 18'h0, 7'h0, 1'b0,18'h0,1'b0,18'h0,1'b0,18'h0,1'b1},
    {13'd7169, 18'h20000, 18'h0, 18'h0, 7'h0, 1'b0,18'h0,1'b0,18'h0,1'b0,18'h0,1'b1},
    {13'd7169, 18'h30000, 18'h0, 18'h0, 7'h0, 1'b0,18'h0,1'b0,18'h0,1'b0,18'h0,1'b0},
    {13'd7169, 18'h00001, 18'h0, 18'h0, 7'h0, 1'b0,18'h0,1'b0,18'h0,1'b0,18'h0,1'b0},
    // R3 B step and test
    {13'd7170, 18'h0, 18'h0, 18'h01FFF, 7'h0, 1'b0,18'h0,1'b0,18'h0,1'b1,18'h02000,1'b1},
    {13'd7170, 18'h0, 18'h0, 18'h00005, 7'h0, 1'b0,18'h0,1'b0,18'h0,1'b1,18'h00006,1'b0},
    {13'd7170, 18'h0, 18'h0, 18'h3FFFF, 7'h0, 1'b0,18'h0,1'b0,18'h0,1'b1,18'h00000,1'b1},
    // R4 A/Q moves
    {13'd7172, 18'h3FFFF, 18'h0, 18'h0, 7'h0, 1'b0,18'h0,1'b1,18'h3FFFE,1'b0,18'h0,1'b0},
    {13'd7173, 18'h0, 18'h2AAAB, 18'h0, 7'h0, 1'b1,18'h15555,1'b0,18'h0,1'b0,18'h0,1'b0},
    // R5 A/B moves
    {13'd7174, 18'h12345, 18'h0, 18'h0, 7'h0, 1'b0,18'h0,1'b0,18'h0,1'b1,18'h12345,1'b0},
    {13'd7175, 18'h0, 18'h0, 18'h0ABCD, 7'h0, 1'b1,18'h0ABCD,1'b0,18'h0,1'b0,18'h0,1'b0},
    // R6 character shift
    {13'd2048, 18'h00801, 18'h0, 18'h0, 7'h55, 1'b1,18'h000D5,1'b0,18'h0,1'b0,18'h0,1'b0},
    {13'd2048, 18'h00003, 18'h0, 18'h0, 7'h7F, 1'b1,18'h001FF,1'b0,18'h0,1'b0,18'h0,1'b0},
    // R7 input / output
    {13'd100,  18'h0, 18'h0, 18'h0, 7'h0, 1'b1,18'h2A5A5,1'b0,18'h0,1'b0,18'h0,1'b0},
    {13'd4100, 18'h11111, 18'h0, 18'h0, 7'h0, 1'b0,18'h0,1'b0,18'h0,1'b0,18'h0,1'b0},
    // R8 undefined values
    {13'd3000, 18'h3FFFF, 18'h3FFFF, 18'h3FFFF, 7'h7F, 1'b0,18'h0,1'b0,18'h0,1'b0,18'h0,1'b0},
    {13'd7171, 18'h0, 18'h0, 18'h0, 7'h0, 1'b0,18'h0,1'b0,18'h0,1'b0,18'h0,1'b0},
    {13'd8191, 18'h0, 18'h0, 18'h0, 7'h0, 1'b0,18'h0,1'b0,18'h0,1'b0,18'h0,1'b0}
  };
  localparam int VREQ [0:NV-1] = '{2,2,2,2,3,3,3,4,4,5,5,6,6,7,7,8,8,8};

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    // R1 reset state
    chk("R1 reset", {level_top, rel_mode, busy, a_we, q_we, b_we, scr_we, skip, mem_req},
        {1'b1, 8'b0});

    // vector table: R2..R8
    for (int i = 0; i < NV; i++) begin
      logic [57:0] act;
      @(negedge clk);
      op_valid = 1'b1;
      {op_field, a_in, q_in, b_in, char_in} = VEC[i][131:58];
      #2;
      act = {a_we, a_we ? a_wd : 18'h0, q_we, q_we ? q_wd : 18'h0,
             b_we, b_we ? b_wd : 18'h0, skip};
      n_chk++;
      if (act !== VEC[i][57:0] || mem_req || scr_we) begin
        n_fail++;
        $display("FAIL R%0d vector %0d: actual %h expected %h", VREQ[i], i, act, VEC[i][57:0]);
      end
    end

    // R7 strobes and channel
    @(negedge clk); op_field = 13'd100; #2;
    chk("R7 input strobe", {io_rd, io_wr, io_chan}, {1'b1, 1'b0, 11'd100});
    @(negedge clk); op_field = 13'd4100; a_in = 18'h1ABCD; #2;
    chk("R7 output strobe", {io_rd, io_wr, io_chan, io_wdata}, {1'b0, 1'b1, 11'd4, 18'h1ABCD});
    @(negedge clk); op_field = 13'd3000; #2;
    chk("R8 no strobe", {io_rd, io_wr, mem_req}, 3'b000);

    // R5 addressing mode
    @(negedge clk); op_field = 13'd7176;
    @(negedge clk); op_valid = 1'b0; #2;
    chk("R5 relative set", rel_mode, 1'b1);
    @(negedge clk); #2;
    chk("R5 mode held", rel_mode, 1'b1);
    @(negedge clk); op_valid = 1'b1; op_field = 13'd7177;
    @(negedge clk); op_valid = 1'b0; #2;
    chk("R5 absolute set", rel_mode, 1'b0);

    // R10 irq masked on the high level
    @(negedge clk); irq = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    chk("R10 irq masked", {busy, mem_req, level_top}, 3'b001);
    irq = 1'b0;

    // R11 exit from the high level, with R12 order during busy
    poke(3'd2, 18'h00400);
    poke(3'd3, 18'h00077);
    @(negedge clk); op_valid = 1'b1; op_field = 13'd7168; #2;
    chk("R11 exit accepted idle", busy, 1'b0);
    @(negedge clk); op_field = 13'd7174; a_in = 18'h3C3C3; #2;
    chk("R11 read word 2", {busy, mem_req, mem_we, mem_addr}, {3'b110, 15'd2});
    chk("R12 order ignored busy", {a_we, b_we, skip, io_rd, io_wr}, 5'b0);
    @(negedge clk); op_valid = 1'b0; #2;
    chk("R11 read word 3 / SCR", {mem_req, mem_addr, scr_we, scr_wd},
        {1'b1, 15'd3, 1'b1, 18'h00400});
    @(negedge clk); #2;
    chk("R11 B restore", {b_we, b_wd, mem_req}, {1'b1, 18'h00077, 1'b0});
    @(negedge clk); #2;
    chk("R11 low level idle", {level_top, busy}, 2'b00);

    // R11 exit order on the low level does nothing
    @(negedge clk); op_valid = 1'b1; op_field = 13'd7168;
    @(negedge clk); op_valid = 1'b0; #2;
    chk("R11 exit on low level", {busy, mem_req, level_top}, 3'b000);

    // R9 entry
    poke(3'd0, 18'h00123);
    poke(3'd1, 18'h00456);
    @(negedge clk); scr_in = 18'h0ABCD; b_in = 18'h01111; irq = 1'b1; #2;
    chk("R9 request cycle idle", busy, 1'b0);
    @(negedge clk); irq = 1'b0; #2;
    chk("R9 save SCR", {mem_req, mem_we, mem_addr, mem_wdata}, {2'b11, 15'd2, 18'h0ABCD});
    @(negedge clk); #2;
    chk("R9 save B", {mem_req, mem_we, mem_addr, mem_wdata}, {2'b11, 15'd3, 18'h01111});
    @(negedge clk); #2;
    chk("R9 read word 0", {mem_req, mem_we, mem_addr, scr_we}, {2'b10, 15'd0, 1'b0});
    @(negedge clk); #2;
    chk("R9 read word 1 / SCR", {mem_req, mem_addr, scr_we, scr_wd},
        {1'b1, 15'd1, 1'b1, 18'h00123});
    @(negedge clk); #2;
    chk("R9 load B", {b_we, b_wd}, {1'b1, 18'h00456});
    @(negedge clk); #2;
    chk("R9 high level idle", {level_top, busy}, 2'b10);
    chk("R9 saved words", {mem[2], mem[3]}, {18'h0ABCD, 18'h01111});

    // R10 irq again on the high level
    @(negedge clk); irq = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    chk("R10 masked after entry", {busy, mem_req}, 2'b00);
    irq = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule